// File: doc/BRIEF.md
# Edge Capture Unit with Prescaler

This block watches an asynchronous input pin and, when a qualified event is seen on it, copies the current value of an external free-running timer into a capture register. Each capture also raises a sticky flag, which is meant to feed an interrupt request; software clears it with a one-cycle pulse. The pin is brought into the clock domain through a flop synchroniser, and edges are detected on the synchronised copy.

A 4-bit mode code selects the event. The unit can capture on every falling edge or on every rising edge. It can also capture on only one rising edge out of every four, or one out of every sixteen, which is done with an internal edge prescaler. A dedicated off code resets the unit. The prescaler count is cleared whenever the mode code changes, so a partial count from an earlier setting never shortens the first period of a new one. The enable input pauses event counting without discarding the count.

Top module: `edge_capture_unit`

## Requirements
- R1: After reset, cap_value is 0 and cap_flag is 0.
- R2: With mode 4'b0101, every rising edge of cap_pin loads timer_val into cap_value. The new value is visible after the third rising clock edge following the pin change, and not after the second. A falling edge causes no capture.
- R3: With mode 4'b0100, every falling edge of cap_pin captures timer_val. A rising edge causes no capture.
- R4: With mode 4'b0110, a capture happens only on the 4th, 8th, ... rising edge counted since the mode was selected.
- R5: With mode 4'b0111, a capture happens only on the 16th, 32nd, ... rising edge counted since the mode was selected.
- R6: Mode 4'b0000 clears cap_value, cap_flag and the prescaler count, and no edge causes a capture while it is selected.
- R7: Any change of the mode code clears the prescaler count, so after a change the full number of edges is needed again.
- R8: Each capture sets cap_flag. The flag stays set until flag_clr is high at a clock edge. A capture in the same cycle as flag_clr leaves the flag set.
- R9: A capture while cap_flag is already set still loads the new timer value.
- R10: While en is low, edges are neither captured nor counted, and the prescaler count is held. Mode codes other than 4'b0000 and 4'b0100 to 4'b0111 never capture.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Event counting enable |
| mode | input | 4 | Event selection code |
| timer_val | input | 16 | Free-running timer value to capture |
| cap_pin | input | 1 | Asynchronous event input |
| flag_clr | input | 1 | Clear pulse for the capture flag |
| cap_value | output | 16 | Last captured timer value |
| cap_flag | output | 1 | Sticky capture flag |

## Verification
The bench builds the unit with its default parameters: a 16-bit timer, two synchroniser stages and prescale ratios of 4 and 16. The ratio of 16 is small enough for the bench to drive a full period and the edge after it, so it can check both the first capture and the absence of an early one. The two-stage synchroniser fixes the latency at three clock edges, and the bench checks that figure exactly. It also uses the prescaler to show the effect of a mode change and of a low enable, because those leave no other trace at the ports.

// File: rtl/ecu_pkg.sv
package ecu_pkg;

  typedef enum logic [3:0] {
    ECU_OFF    = 4'b0000,
    ECU_FALL   = 4'b0100,
    ECU_RISE   = 4'b0101,
    ECU_RISE_A = 4'b0110,
    ECU_RISE_B = 4'b0111
  } ecu_mode_e;

endpackage

// File: rtl/ecu_sync.sv
module ecu_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] sr_q;
  logic [STAGES-1:0] sr_n;

  always_comb begin
    sr_n = {sr_q[STAGES-2:0], d};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_q <= '0;
    else        sr_q <= sr_n;
  end

  assign q = sr_q[STAGES-1];

endmodule

// File: rtl/ecu_evt_qual.sv
module ecu_evt_qual
  import ecu_pkg::*;
#(
  parameter int DIV_A = 4,
  parameter int DIV_B = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic [3:0] mode,
  input  logic       pin_s,
  output logic       cap_evt
);

  localparam int CNT_W = (DIV_B > 2) ? $clog2(DIV_B) : 1;
  localparam logic [CNT_W-1:0] LIM_A = CNT_W'(DIV_A - 1);
  localparam logic [CNT_W-1:0] LIM_B = CNT_W'(DIV_B - 1);

  logic             pin_d_q;
  logic [3:0]       mode_q;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic             rise, fall, sel_edge, mode_chg;
  logic [CNT_W-1:0] lim;

  assign rise     = pin_s & ~pin_d_q;
  assign fall     = ~pin_s & pin_d_q;
  assign mode_chg = (mode != mode_q);

  always_comb begin
    sel_edge = 1'b0;
    lim      = '0;
    case (mode)
      ECU_FALL:   begin sel_edge = fall; lim = '0;    end
      ECU_RISE:   begin sel_edge = rise; lim = '0;    end
      ECU_RISE_A: begin sel_edge = rise; lim = LIM_A; end
      ECU_RISE_B: begin sel_edge = rise; lim = LIM_B; end
      default:    begin sel_edge = 1'b0; lim = '0;    end
    endcase
  end

  always_comb begin
    cnt_n   = cnt_q;
    cap_evt = 1'b0;
    if (mode_chg || (mode == ECU_OFF)) begin
      cnt_n = '0;
    end else if (en && sel_edge) begin
      if (cnt_q == lim) begin
        cap_evt = 1'b1;
        cnt_n   = '0;
      end else begin
        cnt_n = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_d_q <= 1'b0;
      mode_q  <= 4'b0000;
      cnt_q   <= '0;
    end else begin
      pin_d_q <= pin_s;
      mode_q  <= mode;
      cnt_q   <= cnt_n;
    end
  end

  // R6
  off_clears_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == ECU_OFF) |=> (cnt_q == '0));

  // R7
  mode_chg_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != mode_q) |=> (cnt_q == '0));

  // R10
  en_low_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && mode == mode_q && mode != ECU_OFF) |=> $stable(cnt_q));

endmodule

// File: rtl/ecu_cap_reg.sv
module ecu_cap_reg #(
  parameter int TMR_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear_all,
  input  logic             cap_evt,
  input  logic             flag_clr,
  input  logic [TMR_W-1:0] timer_val,
  output logic [TMR_W-1:0] cap_value,
  output logic             cap_flag
);

  logic [TMR_W-1:0] val_q, val_n;
  logic             flag_q, flag_n;
  logic             val_en;

  always_comb begin
    val_en = clear_all | cap_evt;
    val_n  = clear_all ? '0 : timer_val;
    if (clear_all)     flag_n = 1'b0;
    else if (cap_evt)  flag_n = 1'b1;
    else if (flag_clr) flag_n = 1'b0;
    else               flag_n = flag_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      val_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      if (val_en) val_q <= val_n;
      flag_q <= flag_n;
    end
  end

  assign cap_value = val_q;
  assign cap_flag  = flag_q;

  // R8 R9
  cap_loads_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_evt && !clear_all) |=> (cap_flag && cap_value == $past(timer_val)));

  // R8
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_flag && !flag_clr && !clear_all) |=> cap_flag);

  // R6
  off_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clear_all |=> (cap_value == '0 && !cap_flag));

  // R2
  value_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cap_evt && !clear_all) |=> $stable(cap_value));

endmodule

// File: rtl/edge_capture_unit.sv
module edge_capture_unit
  import ecu_pkg::*;
#(
  parameter int TMR_W       = 16,
  parameter int SYNC_STAGES = 2,
  parameter int DIV_A       = 4,
  parameter int DIV_B       = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [3:0]       mode,
  input  logic [TMR_W-1:0] timer_val,
  input  logic             cap_pin,
  input  logic             flag_clr,
  output logic [TMR_W-1:0] cap_value,
  output logic             cap_flag
);

  logic pin_s;
  logic cap_evt;
  logic off_sel;

  assign off_sel = (mode == ECU_OFF);

  ecu_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (cap_pin),
    .q     (pin_s)
  );

  ecu_evt_qual #(.DIV_A(DIV_A), .DIV_B(DIV_B)) u_qual (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (en),
    .mode    (mode),
    .pin_s   (pin_s),
    .cap_evt (cap_evt)
  );

  ecu_cap_reg #(.TMR_W(TMR_W)) u_reg (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear_all (off_sel),
    .cap_evt   (cap_evt),
    .flag_clr  (flag_clr),
    .timer_val (timer_val),
    .cap_value (cap_value),
    .cap_flag  (cap_flag)
  );

  // R10
  bad_mode_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode[3] || mode[3:2] == 2'b00) |-> !cap_evt);

endmodule

// File: tb/edge_capture_unit_tb.sv
module edge_capture_unit_tb;

  localparam int CLK_P   = 10;
  localparam int WD_MAX  = 20000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        en;
  logic [3:0]  mode;
  logic [15:0] timer_val;
  logic        cap_pin;
  logic        flag_clr;
  logic [15:0] cap_value;
  logic        cap_flag;

  int checks = 0;
  int errors = 0;
  int cyc    = 0;

  always #(CLK_P/2) clk = ~clk;

  edge_capture_unit u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (en),
    .mode      (mode),
    .timer_val (timer_val),
    .cap_pin   (cap_pin),
    .flag_clr  (flag_clr),
    .cap_value (cap_value),
    .cap_flag  (cap_flag)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > WD_MAX) begin
      errors = errors + 1;
      $display("FAIL watchdog: actual %0d cycles expected below %0d", cyc, WD_MAX);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic set_mode(input logic [3:0] m);
    @(negedge clk);
    mode = m;
    cycles(3);
  endtask

  task automatic pulse(input logic [15:0] t);
    @(negedge clk);
    timer_val = t;
    cap_pin = 1'b1;
    cycles(5);
    cap_pin = 1'b0;
    cycles(5);
  endtask

  task automatic clr_flag();
    @(negedge clk);
    flag_clr = 1'b1;
    @(negedge clk);
    flag_clr = 1'b0;
  endtask

  task automatic t_reset();
    rst_n = 1'b0; en = 1'b1; mode = 4'b0000; timer_val = '0;
    cap_pin = 1'b0; flag_clr = 1'b0;
    cycles(3);
    rst_n = 1'b1;
    cycles(2);
    chk(cap_value == 16'h0, "R1 value", 32'(cap_value), 32'h0);
    chk(cap_flag == 1'b0, "R1 flag", 32'(cap_flag), 32'h0);
  endtask

  task automatic t_rise();
    set_mode(4'b0101);
    @(negedge clk);
    timer_val = 16'h1234;
    cap_pin = 1'b1;
    @(posedge clk); @(posedge clk); #1;
    chk(cap_value == 16'h0, "R2 early", 32'(cap_value), 32'h0);
    @(posedge clk); #1;
    chk(cap_value == 16'h1234, "R2 latency", 32'(cap_value), 32'h1234);
    chk(cap_flag == 1'b1, "R8 set", 32'(cap_flag), 32'h1);
    cycles(3);
    timer_val = 16'h5555;
    cap_pin = 1'b0;
    cycles(5);
    chk(cap_value == 16'h1234, "R2 fall ignored", 32'(cap_value), 32'h1234);
  endtask

  task automatic t_flag();
    cycles(4);
    chk(cap_flag == 1'b1, "R8 sticky", 32'(cap_flag), 32'h1);
    pulse(16'h2222);
    chk(cap_value == 16'h2222, "R9 recapture", 32'(cap_value), 32'h2222);
    clr_flag();
    chk(cap_flag == 1'b0, "R8 clear", 32'(cap_flag), 32'h0);
    @(negedge clk);
    timer_val = 16'h2323;
    cap_pin = 1'b1;
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    flag_clr = 1'b1;
    @(negedge clk);
    flag_clr = 1'b0;
    chk(cap_flag == 1'b1, "R8 set wins", 32'(cap_flag), 32'h1);
    chk(cap_value == 16'h2323, "R8 value", 32'(cap_value), 32'h2323);
    cycles(3);
    cap_pin = 1'b0;
    cycles(5);
  endtask

  task automatic t_fall();
    set_mode(4'b0100);
    clr_flag();
    @(negedge clk);
    timer_val = 16'h3333;
    cap_pin = 1'b1;
    cycles(5);
    chk(cap_flag == 1'b0, "R3 rise ignored", 32'(cap_flag), 32'h0);
    cap_pin = 1'b0;
    cycles(5);
    chk(cap_value == 16'h3333, "R3 fall capture", 32'(cap_value), 32'h3333);
    chk(cap_flag == 1'b1, "R3 flag", 32'(cap_flag), 32'h1);
  endtask

  task automatic t_div4();
    set_mode(4'b0110);
    clr_flag();
    for (int k = 1; k <= 3; k++) pulse(16'h4000 + 16'(k));
    chk(cap_flag == 1'b0, "R4 no early", 32'(cap_flag), 32'h0);
    pulse(16'h4004);
    chk(cap_value == 16'h4004, "R4 4th", 32'(cap_value), 32'h4004);
    clr_flag();
    for (int k = 5; k <= 7; k++) pulse(16'h4000 + 16'(k));
    chk(cap_flag == 1'b0, "R4 second period", 32'(cap_flag), 32'h0);
    pulse(16'h4008);
    chk(cap_value == 16'h4008, "R4 8th", 32'(cap_value), 32'h4008);
  endtask

  task automatic t_div16();
    set_mode(4'b0111);
    clr_flag();
    for (int k = 1; k <= 15; k++) pulse(16'h6000 + 16'(k));
    chk(cap_flag == 1'b0, "R5 no early", 32'(cap_flag), 32'h0);
    pulse(16'h6010);
    chk(cap_value == 16'h6010, "R5 16th", 32'(cap_value), 32'h6010);
  endtask

  task automatic t_modechg();
    set_mode(4'b0110);
    clr_flag();
    pulse(16'h7001);
    pulse(16'h7002);
    set_mode(4'b0101);
    set_mode(4'b0110);
    for (int k = 3; k <= 5; k++) pulse(16'h7000 + 16'(k));
    chk(cap_flag == 1'b0, "R7 count cleared", 32'(cap_flag), 32'h0);
    pulse(16'h7006);
    chk(cap_value == 16'h7006, "R7 full period", 32'(cap_value), 32'h7006);
  endtask

  task automatic t_enable();
    set_mode(4'b0101);
    set_mode(4'b0110);
    clr_flag();
    pulse(16'h8001);
    pulse(16'h8002);
    @(negedge clk); en = 1'b0;
    for (int k = 3; k <= 5; k++) pulse(16'h8000 + 16'(k));
    chk(cap_flag == 1'b0, "R10 en low", 32'(cap_flag), 32'h0);
    @(negedge clk); en = 1'b1;
    pulse(16'h8006);
    chk(cap_flag == 1'b0, "R10 count held", 32'(cap_flag), 32'h0);
    pulse(16'h8007);
    chk(cap_value == 16'h8007, "R10 resume", 32'(cap_value), 32'h8007);
    set_mode(4'b1000);
    clr_flag();
    pulse(16'h8888);
    chk(cap_flag == 1'b0 && cap_value == 16'h8007, "R10 bad mode",
        {15'h0, cap_flag, cap_value}, 32'h0000_8007);
  endtask

  task automatic t_off();
    set_mode(4'b0101);
    pulse(16'h9999);
    chk(cap_flag == 1'b1, "R6 setup", 32'(cap_flag), 32'h1);
    set_mode(4'b0000);
    chk(cap_value == 16'h0, "R6 value cleared", 32'(cap_value), 32'h0);
    chk(cap_flag == 1'b0, "R6 flag cleared", 32'(cap_flag), 32'h0);
    pulse(16'h9a9a);
    chk(cap_value == 16'h0 && cap_flag == 1'b0, "R6 no capture",
        {15'h0, cap_flag, cap_value}, 32'h0);
  endtask

  initial begin
    t_reset();
    t_rise();
    t_flag();
    t_fall();
    t_div4();
    t_div16();
    t_modechg();
    t_enable();
    t_off();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule